// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns activity on two dedicated interrupt pins and on a group of eight pin-change inputs into interrupt requests for a processor core. Each dedicated pin has its own 2-bit sense field. The field selects one of four detection modes: low level, any change, falling edge or rising edge. Each pin-change input passes through a mask bit, and the masked inputs are merged into one request. Edge and change events set sticky flags. Software clears a flag by writing a 1 to it, and the hardware also clears it when the core accepts that vector.

All three sources are detected on synchronized samples. Edge detection compares the output of a two-flop synchronizer with a register that holds the previous sample. A source reaches the core only when its own enable and the global enable are both set. A small arbiter with two states, `ARB_IDLE` and `ARB_OFFER`, picks the pending source with the highest priority and holds its vector number until the core acknowledges it. The transitions are:
- GRANT: `ARB_IDLE` to `ARB_OFFER`, when any source can be delivered.
- ACCEPT: `ARB_OFFER` to `ARB_IDLE`, on an acknowledge.
- WITHDRAW: `ARB_OFFER` to `ARB_IDLE`, when the offered source stops being deliverable.
- HOLD: stay in `ARB_OFFER` otherwise.

A separate combinational wake output reacts to the raw pins and needs no clock. It can therefore rouse the system while the I/O clock is stopped. Detection looks only at the input value, so a pin that the core drives as an output can raise an interrupt from software.

Top module: `ext_irq_sense`

## Requirements
- R1: The sense field of each dedicated pin encodes 00 = low level, 01 = any change, 10 = falling edge, 11 = rising edge. In modes 01, 10 and 11 a matching transition sets that pin's sticky flag, and a transition that does not match leaves the flag clear. Pin 0 uses bits [1:0] of register 0 and pin 1 uses bits [3:2].
- R2: In mode 00 the pin's request is present exactly while the synchronized pin is low. It sets no flag, an acknowledge does not remove it, and it disappears once the pin returns high.
- R3: In an edge mode, a pulse on a dedicated pin that lasts two clock periods produces a flag.
- R4: A toggle on pin-change input i sets the pin-change flag when bit i of the mask (register 2) is 1. When bit i is 0 the toggle is ignored.
- R5: The wake output is the OR of two terms, and it responds to the raw pins within the same cycle, with no clock edge. The first term covers each dedicated pin that is enabled, in mode 00 and low. The second term is set when the pin-change source is enabled and some masked input differs from its last registered sample.
- R6: A source is delivered only when the global enable and its own enable bit are both 1. The enable bits are in register 1: bit 0 for pin 0, bit 1 for pin 1, bit 2 for pin change. Flags are set whatever the enables hold.
- R7: The flags are output on `flags` and written through register 3: bit 0 is pin 0, bit 1 is pin 1, bit 2 is pin change. Writing a 1 clears that flag, and writing a 0 leaves it unchanged. A new event in the same cycle as a clear wins.
- R8: When the core acknowledges an offered vector, the sticky flag of that source clears at the same clock edge.
- R9: When several sources are deliverable, the vector offered on `irq_vec` follows a fixed priority: 0 (pin 0) first, then 1 (pin 1), then 2 (pin change).
- R10: After reset all sense fields are 00, and all enables, masks and flags are 0. `irq_req` and `wake` are then low while the dedicated pins are high.
- R11: Once a vector has been offered, it stays on `irq_vec` until it is acknowledged or withdrawn, even if a source with higher priority becomes deliverable in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ded_pin | input | 2 | Dedicated interrupt pins |
| chg_pin | input | 8 | Pin-change inputs |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 sense, 1 enables, 2 mask, 3 flag clear |
| wr_data | input | 8 | Write data |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Core accepts the offered vector |
| irq_req | output | 1 | An interrupt is offered |
| irq_vec | output | 2 | Vector number of the offer |
| flags | output | 3 | Sticky flags {pin change, pin 1, pin 0} |
| wake | output | 1 | Clock-free wake request |

## Verification
The hardest situation to reach is R11: the arbiter must hold a vector with lower priority while a source with higher priority becomes deliverable. The bench first sets all three flags. It then disables pin 0 while that pin is being offered, which withdraws the offer and moves the arbiter on to pin 1. Finally it enables pin 0 again during the pin-1 offer and checks that the vector does not change until the acknowledge. The wake term of R5 is checked one time unit after the raw pin moves, before any clock edge can reach the synchronizer.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef enum logic [0:0] {
        ARB_IDLE  = 1'b0,
        ARB_OFFER = 1'b1
    } arb_state_e;

    localparam int NUM_DED  = 2;
    localparam int NUM_SRC  = NUM_DED + 1;
    localparam int VEC_W    = $clog2(NUM_SRC);
    localparam int SENSE_W  = 2;

    localparam logic [1:0] REG_SENSE = 2'd0;
    localparam logic [1:0] REG_EN    = 2'd1;
    localparam logic [1:0] REG_MASK  = 2'd2;
    localparam logic [1:0] REG_FLAG  = 2'd3;
endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            out_q  <= '0;
        end else begin
            meta_q <= d;
            out_q  <= meta_q;
        end
    end

    assign q = out_q;
endmodule

// File: rtl/eis_pin_detect.sv
module eis_pin_detect
    import ext_irq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pin_raw,
    input  sense_e sense,
    input  logic   en,
    input  logic   sw_clr,
    input  logic   ack_clr,
    output logic   flag_o,
    output logic   pend_o,
    output logic   wake_o
);
    logic [0:0] s_vec;
    logic       s;
    logic       prev_q;
    logic       flag_q;
    logic       rise;
    logic       fall;
    logic       hit;

    eis_sync #(.W(1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pin_raw),
        .q    (s_vec)
    );
    assign s = s_vec[0];

    always_comb begin
        rise = s & ~prev_q;
        fall = ~s & prev_q;
        unique case (sense)
            SENSE_LOW:  hit = 1'b0;
            SENSE_ANY:  hit = rise | fall;
            SENSE_FALL: hit = fall;
            SENSE_RISE: hit = rise;
            default:    hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            prev_q <= s;
            if (hit)
                flag_q <= 1'b1;
            else if (sw_clr || ack_clr)
                flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
    assign pend_o = flag_q | ((sense == SENSE_LOW) & ~s);
    assign wake_o = en & (sense == SENSE_LOW) & ~pin_raw;

    // R1: a rising sample pair in rise mode leaves the flag set
    p_rise_sets_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sense == SENSE_RISE && s && !prev_q) |=> flag_q);

    // R2: low-level mode never creates a flag on its own
    p_level_no_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sense == SENSE_LOW && !flag_q && !sw_clr) |=> !flag_q);

    // R7: a write-one clear without a new event empties the flag
    p_w1c_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr && !hit) |=> !flag_q);

    // R8: acknowledge without a new event empties the flag
    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_clr && !hit) |=> !flag_q);
endmodule

// File: rtl/eis_chg_detect.sv
module eis_chg_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_raw,
    input  logic [W-1:0] mask,
    input  logic         en,
    input  logic         sw_clr,
    input  logic         ack_clr,
    output logic         flag_o,
    output logic         wake_o
);
    logic [W-1:0] s;
    logic [W-1:0] ref_q;
    logic         flag_q;
    logic         hit;

    eis_sync #(.W(W)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pins_raw),
        .q    (s)
    );

    assign hit = |((s ^ ref_q) & mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            ref_q <= s;
            if (hit)
                flag_q <= 1'b1;
            else if (sw_clr || ack_clr)
                flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
    assign wake_o = en & |((pins_raw ^ ref_q) & mask);

    // R4: with every input masked off the flag cannot rise
    p_mask_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0 && !flag_q) |=> !flag_q);

    // R5: with the source disabled there is no pin-change wake
    p_wake_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !wake_o);
endmodule

// File: rtl/eis_arbiter.sv
module eis_arbiter
    import ext_irq_pkg::*;
#(
    parameter int N  = NUM_SRC,
    parameter int VW = VEC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  deliv,
    input  logic          gie,
    input  logic          ack,
    output logic          irq_req,
    output logic [VW-1:0] irq_vec,
    output logic [N-1:0]  ack_src
);
    arb_state_e    state_q, state_d;
    logic [VW-1:0] vec_q, vec_d;
    logic [VW-1:0] pick;
    logic          held_ok;

    always_comb begin
        pick = '0;
        for (int i = N - 1; i >= 0; i--)
            if (deliv[i]) pick = VW'(i);
        held_ok = 1'b0;
        for (int i = 0; i < N; i++)
            if (vec_q == VW'(i)) held_ok = deliv[i];
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            vec_q   <= vec_d;
        end
    end

    // transitions: GRANT, ACCEPT, WITHDRAW, HOLD
    always_comb begin
        state_d = state_q;
        vec_d   = vec_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (|deliv) begin
                    state_d = ARB_OFFER;
                    vec_d   = pick;
                end
            end
            ARB_OFFER: begin
                if (!held_ok || ack)
                    state_d = ARB_IDLE;
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        irq_req = (state_q == ARB_OFFER) && held_ok;
        irq_vec = vec_q;
        ack_src = '0;
        for (int i = 0; i < N; i++)
            if (irq_req && ack && vec_q == VW'(i)) ack_src[i] = 1'b1;
    end

    // R6: nothing is offered without the global enable
    p_gie_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> gie);

    // R9: source 0 deliverable while idle wins the next grant
    p_prio_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_IDLE && deliv[0]) |=> (irq_vec == '0));

    // R11: the vector stays put while the offer is held
    p_vec_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_OFFER && held_ok && !ack) |=> $stable(irq_vec));

    // R8: at most one source is cleared per acknowledge
    p_ack_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_src));
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
    import ext_irq_pkg::*;
#(
    parameter int CHG_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        ded_pin,
    input  logic [CHG_W-1:0]  chg_pin,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              gie,
    input  logic              irq_ack,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec,
    output logic [NUM_SRC-1:0] flags,
    output logic              wake
);
    localparam int SENSE_BITS = NUM_DED * SENSE_W;

    logic [SENSE_BITS-1:0] sense_q;
    logic [NUM_SRC-1:0]    en_q;
    logic [CHG_W-1:0]      mask_q;
    logic [NUM_SRC-1:0]    sw_clr;
    logic [NUM_SRC-1:0]    ack_src;
    logic [NUM_SRC-1:0]    deliv;
    logic [NUM_DED-1:0]    ded_pend;
    logic [NUM_DED-1:0]    ded_wake;
    logic                  chg_wake;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sense_q <= '0;
            en_q    <= '0;
            mask_q  <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                REG_SENSE: sense_q <= wr_data[SENSE_BITS-1:0];
                REG_EN:    en_q    <= wr_data[NUM_SRC-1:0];
                REG_MASK:  mask_q  <= wr_data[CHG_W-1:0];
                default:   ;
            endcase
        end
    end

    assign sw_clr = (wr_en && wr_addr == REG_FLAG) ? wr_data[NUM_SRC-1:0] : '0;

    for (genvar g = 0; g < NUM_DED; g++) begin : g_ded
        eis_pin_detect u_det (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_raw(ded_pin[g]),
            .sense  (sense_e'(sense_q[g*SENSE_W +: SENSE_W])),
            .en     (en_q[g]),
            .sw_clr (sw_clr[g]),
            .ack_clr(ack_src[g]),
            .flag_o (flags[g]),
            .pend_o (ded_pend[g]),
            .wake_o (ded_wake[g])
        );
        assign deliv[g] = gie & en_q[g] & ded_pend[g];
    end

    eis_chg_detect #(.W(CHG_W)) u_chg (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_raw(chg_pin),
        .mask    (mask_q),
        .en      (en_q[NUM_DED]),
        .sw_clr  (sw_clr[NUM_DED]),
        .ack_clr (ack_src[NUM_DED]),
        .flag_o  (flags[NUM_DED]),
        .wake_o  (chg_wake)
    );
    assign deliv[NUM_DED] = gie & en_q[NUM_DED] & flags[NUM_DED];

    eis_arbiter #(.N(NUM_SRC), .VW(VEC_W)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .deliv  (deliv),
        .gie    (gie),
        .ack    (irq_ack),
        .irq_req(irq_req),
        .irq_vec(irq_vec),
        .ack_src(ack_src)
    );

    assign wake = (|ded_wake) | chg_wake;

    // R10: right after reset nothing is flagged
    p_reset_clean_r10: assert property (@(posedge clk)
        !rst_n |=> (flags == '0));

    // R6: a disabled pin-0 source is never offered as vector 0
    p_en_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_vec == '0) |-> en_q[0]);
endmodule

// File: tb/ext_irq_sense_test.sv
module ext_irq_sense_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ded_pin = 2'b11;
    logic [7:0] chg_pin = 8'h00;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic       gie = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq_req;
    logic [1:0] irq_vec;
    logic [2:0] flags;
    logic       wake;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ext_irq_sense uut (
        .clk(clk), .rst_n(rst_n), .ded_pin(ded_pin), .chg_pin(chg_pin),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .gie(gie),
        .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec),
        .flags(flags), .wake(wake)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic ack_pulse();
        irq_ack = 1'b1;
        step(1);
        irq_ack = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(4);
        // R10 reset state
        chk("R10", "flags", 32'(flags), 0);
        chk("R10", "irq_req", 32'(irq_req), 0);
        chk("R10", "wake", 32'(wake), 0);

        // R1 / R2 / R5: sweep every sense mode, both pins, both directions
        wr(2'd1, 8'h03);
        for (int p = 0; p < 2; p++) begin
            for (int m = 0; m < 4; m++) begin
                for (int st = 0; st < 2; st++) begin
                    bit nw;
                    bit exp_f;
                    bit exp_w;
                    wr(2'd0, 8'(m << (2 * p)));
                    ded_pin[p] = st[0];
                    step(4);
                    wr(2'd3, 8'h07);
                    step(1);
                    nw = ~st[0];
                    ded_pin[p] = nw;
                    exp_w = (m == 0) && (nw == 1'b0);
                    exp_f = (m == 1) || (m == 2 && st == 1) || (m == 3 && st == 0);
                    #1;
                    chk("R5", $sformatf("level wake p%0d m%0d", p, m), 32'(wake), 32'(exp_w));
                    step(4);
                    chk(m == 0 ? "R2" : "R1", $sformatf("flag p%0d m%0d s%0d", p, m, st),
                        32'(flags[p]), 32'(exp_f));
                    ded_pin[p] = 1'b1;
                    step(4);
                    wr(2'd3, 8'h07);
                end
            end
        end

        // R3: two-cycle pulses in rise and fall modes on pin 0
        wr(2'd0, 8'h03);
        ded_pin[0] = 1'b0; step(4); wr(2'd3, 8'h07); step(1);
        ded_pin[0] = 1'b1; step(2); ded_pin[0] = 1'b0; step(4);
        chk("R3", "rise pulse flag", 32'(flags[0]), 1);
        wr(2'd0, 8'h02);
        ded_pin[0] = 1'b1; step(4); wr(2'd3, 8'h07); step(1);
        ded_pin[0] = 1'b0; step(2); ded_pin[0] = 1'b1; step(4);
        chk("R3", "fall pulse flag", 32'(flags[0]), 1);
        wr(2'd3, 8'h07);

        // R4 / R5: pin-change sweep, each input masked in and out
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h04);
        for (int i = 0; i < 8; i++) begin
            for (int m = 0; m < 2; m++) begin
                wr(2'd2, m ? 8'(1 << i) : ~8'(1 << i));
                wr(2'd3, 8'h07);
                step(1);
                chg_pin[i] = ~chg_pin[i];
                #1;
                chk("R5", $sformatf("chg wake bit%0d m%0d", i, m), 32'(wake), 32'(m));
                step(4);
                chk("R4", $sformatf("chg flag bit%0d m%0d", i, m), 32'(flags[2]), 32'(m));
                chk("R5", $sformatf("chg wake settled bit%0d", i), 32'(wake), 0);
                wr(2'd3, 8'h07);
            end
        end

        // R6 / R9 / R11 / R8: priority, gating, hold and acknowledge
        wr(2'd2, 8'h01);
        wr(2'd0, 8'h0A);
        wr(2'd1, 8'h07);
        ded_pin = 2'b00;
        chg_pin[0] = ~chg_pin[0];
        step(4);
        chk("R6", "flags set with gie off", 32'(flags), 7);
        chk("R6", "no req with gie off", 32'(irq_req), 0);
        gie = 1'b1;
        step(2);
        chk("R9", "req all pending", 32'(irq_req), 1);
        chk("R9", "vec pin0 first", 32'(irq_vec), 0);
        wr(2'd1, 8'h06);
        chk("R6", "req drops on disable", 32'(irq_req), 0);
        step(2);
        chk("R11", "withdraw then vec1", 32'(irq_vec), 1);
        wr(2'd1, 8'h07);
        step(2);
        chk("R11", "vec1 held", 32'(irq_vec), 1);
        chk("R11", "req held", 32'(irq_req), 1);
        ack_pulse();
        chk("R8", "flag1 cleared by ack", 32'(flags), 3'b101);
        step(1);
        chk("R9", "vec0 after ack", 32'(irq_vec), 0);
        ack_pulse();
        chk("R8", "flag0 cleared by ack", 32'(flags), 3'b100);
        step(1);
        chk("R9", "vec2 last", 32'(irq_vec), 2);
        ack_pulse();
        chk("R8", "all flags cleared", 32'(flags), 0);
        step(1);
        chk("R8", "no req after acks", 32'(irq_req), 0);

        // R7: write-one-to-clear
        gie = 1'b0;
        ded_pin = 2'b11; step(4);
        ded_pin = 2'b00; step(4);
        chk("R7", "two flags set", 32'(flags), 3'b011);
        wr(2'd3, 8'h00);
        chk("R7", "write zero keeps", 32'(flags), 3'b011);
        wr(2'd3, 8'h02);
        chk("R7", "clear bit1 only", 32'(flags), 3'b001);
        wr(2'd3, 8'h01);
        chk("R7", "clear bit0", 32'(flags), 0);

        // R2: level request persists through ack, withdraws on release
        ded_pin[1] = 1'b1;
        wr(2'd0, 8'h00);
        gie = 1'b1;
        step(4);
        chk("R2", "level req", 32'(irq_req), 1);
        chk("R2", "level vec", 32'(irq_vec), 0);
        chk("R2", "level no flag", 32'(flags), 0);
        ack_pulse();
        step(1);
        chk("R2", "level survives ack", 32'(irq_req), 1);
        ded_pin[0] = 1'b1;
        step(4);
        chk("R2", "level released", 32'(irq_req), 0);
        chk("R5", "wake off after release", 32'(wake), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule